// File: doc/BRIEF.md
# Octal Common-Start Time Digitizer

This block measures time intervals on eight channels that share one start input. Each channel has its own stop input. A channel counts clock cycles from the leading edge of the common start to the leading edge of its own stop. A conversion ends when the stop arrives, when a fast clear aborts it, or when the count reaches full scale, whichever happens first. Full scale is 95% of the counter range. A common test-stop input stops every running channel at once. A self-test request runs an internal start and then a timed common stop, so that each channel reads 80% of full scale.

Every asynchronous control input passes through a two-flop synchronizer and a rising-edge detector. After a conversion finishes, the results stay unchanged until a fast clear. A look-at-me request (LAM) is raised once all channels have finished, provided it is enabled and at least one channel holds a nonzero result. Results are read through a request/response port with valid/ready handshakes. A request is taken when `rd_req_valid_i` and `rd_req_ready_o` are both high. The response stays on the outputs, unchanged, until `rd_rsp_ready_i` accepts it. While a response is waiting, the request side deasserts ready, so back-pressure reaches the requester without any loss.

Top module: `tdc_octal`

## Requirements
- R1: An input that rises is seen as a pulse two clocks later. If start rises N clocks before a channel's stop rises, with 1 <= N < 1945, that channel reads N. The result word is {overflow (bit 11), count (bits 10:0)}.
- R2: A channel discards a stop whose rising edge comes before the accepted start or in the same clock as it. After accepting one stop, the channel ignores any further stop edges.
- R3: A channel that gets no stop by count 1945 holds 1945 with overflow bit 11 set. A stop that lands exactly at count 1945 gives 1945 with bit 11 clear.
- R4: A rising edge on `test_stop_i` stops every channel that is still running, in the same clock. Channels that have already stopped keep their values.
- R5: A rising edge on `selftest_i` while idle starts a conversion with an internal stop, and every channel reads 1556 with bit 11 clear.
- R6: A rising edge on `fast_clr_i` at any point zeroes all results and overflow bits, ends any conversion (`busy_o` low), and drops LAM.
- R7: Once a conversion has started, further start or self-test edges are ignored until a fast clear.
- R8: `lam_o` is high exactly when `lam_en_i` is high, the conversion has finished, and some channel is nonzero.
- R9: `any_data_o` is high when any channel result is nonzero. Each read response carries `rd_rsp_q_o`, which equals `any_data_o` at the moment the request was taken, so it is low when every channel is empty.
- R10: While `rd_rsp_valid_o` is high and `rd_rsp_ready_i` is low, the response data holds steady and `rd_req_ready_o` is low.
- R11: After reset, all results are zero, `busy_o`, `lam_o`, `any_data_o` and `rd_rsp_valid_o` are low, and `rd_req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Common start, asynchronous |
| stop_i | input | 8 | Per-channel stops, asynchronous |
| test_stop_i | input | 1 | Common stop for all channels |
| selftest_i | input | 1 | Self-test request |
| fast_clr_i | input | 1 | Fast clear |
| lam_en_i | input | 1 | LAM enable |
| rd_req_valid_i | input | 1 | Read request valid |
| rd_req_ready_o | output | 1 | Read request ready |
| rd_addr_i | input | 3 | Channel to read |
| rd_rsp_valid_o | output | 1 | Response valid |
| rd_rsp_ready_i | input | 1 | Response ready |
| rd_rsp_data_o | output | 12 | {overflow, count} |
| rd_rsp_q_o | output | 1 | Data-present flag of the response |
| busy_o | output | 1 | Conversion running |
| any_data_o | output | 1 | Some channel is nonzero |
| lam_o | output | 1 | Look-at-me request |

## Verification
A table of stop patterns drives the measurement path. One pattern gives short staggered delays, which separates the channels from each other. One gives all channels the same delay, which catches crosstalk between them. One sends no stops at all, so every channel must end at the overflow value. One mixes values around full scale (1944, 1945, 1946), which pins down the off-by-one and the precedence between a stop and overflow. Directed runs add an early stop, a stop in the same clock as start, and a repeated stop. They also cover a test-stop that overrides pending channels, self-test, a clear in the middle of a conversion, a start while results are held, LAM gating, and a read response held under back-pressure.

// File: rtl/tdc_octal_pkg.sv
package tdc_octal_pkg;
  typedef enum logic [1:0] {
    CV_IDLE = 2'd0,
    CV_RUN  = 2'd1,
    CV_DONE = 2'd2
  } cv_state_e;

  function automatic int unsigned pct_of(input int unsigned base, input int unsigned pct);
    return (base * pct) / 100;
  endfunction
endpackage

// File: rtl/tdc_sync_edge.sv
module tdc_sync_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/tdc_channel.sv
module tdc_channel #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned FULL  = 1945
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             run_o,
  output logic [CNT_W-1:0] val_o,
  output logic             ovf_o
);
  logic             run_q, ovf_q;
  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] nxt;

  assign nxt = val_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ovf_q <= 1'b0;
      val_q <= '0;
    end else if (clr_i) begin
      run_q <= 1'b0;
      ovf_q <= 1'b0;
      val_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      ovf_q <= 1'b0;
      val_q <= '0;
    end else if (run_q) begin
      val_q <= nxt;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (nxt == CNT_W'(FULL)) begin
        run_q <= 1'b0;
        ovf_q <= 1'b1;
      end
    end
  end

  assign run_o = run_q;
  assign val_o = val_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_octal_pkg::*;
#(
  parameter int unsigned N_CH     = 8,
  parameter int unsigned SELF_CNT = 1556
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            start_i,
  input  logic            selftest_i,
  input  logic [N_CH-1:0] run_i,
  output logic            chan_start_o,
  output logic            self_stop_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int unsigned STW = $clog2(SELF_CNT + 1);

  cv_state_e      state_q;
  logic           st_run_q;
  logic [STW-1:0] st_cnt_q;
  logic           accept;
  logic           st_hit;

  assign accept = (state_q == CV_IDLE) && (start_i || selftest_i) && !clr_i;
  assign st_hit = st_run_q && (st_cnt_q == STW'(SELF_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CV_IDLE;
      st_run_q <= 1'b0;
      st_cnt_q <= '0;
    end else if (clr_i) begin
      state_q  <= CV_IDLE;
      st_run_q <= 1'b0;
      st_cnt_q <= '0;
    end else begin
      case (state_q)
        CV_IDLE: begin
          if (accept) begin
            state_q <= CV_RUN;
            if (selftest_i) begin
              st_run_q <= 1'b1;
              st_cnt_q <= STW'(1);
            end
          end
        end
        CV_RUN: begin
          if (st_run_q) begin
            if (st_hit) st_run_q <= 1'b0;
            else        st_cnt_q <= st_cnt_q + 1'b1;
          end
          if (~|run_i) state_q <= CV_DONE;
        end
        default: ;
      endcase
    end
  end

  assign chan_start_o = accept;
  assign self_stop_o  = st_hit;
  assign busy_o       = (state_q == CV_RUN);
  assign done_o       = (state_q == CV_DONE);
endmodule

// File: rtl/tdc_octal.sv
module tdc_octal
  import tdc_octal_pkg::*;
#(
  parameter int unsigned N_CH     = 8,
  parameter int unsigned CNT_W    = 11,
  parameter int unsigned FS_PCT   = 95,
  parameter int unsigned SELF_PCT = 80,
  parameter int unsigned AW       = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [N_CH-1:0]  stop_i,
  input  logic             test_stop_i,
  input  logic             selftest_i,
  input  logic             fast_clr_i,
  input  logic             lam_en_i,
  input  logic             rd_req_valid_i,
  output logic             rd_req_ready_o,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             rd_rsp_valid_o,
  input  logic             rd_rsp_ready_i,
  output logic [CNT_W:0]   rd_rsp_data_o,
  output logic             rd_rsp_q_o,
  output logic             busy_o,
  output logic             any_data_o,
  output logic             lam_o
);
  localparam int unsigned FULL     = pct_of(2 ** CNT_W, FS_PCT);
  localparam int unsigned SELF_CNT = pct_of(FULL, SELF_PCT);
  localparam int unsigned SW       = N_CH + 4;

  logic [SW-1:0] raw_in, pulse;
  logic [N_CH-1:0] stop_p;
  logic start_p, tstop_p, self_p, clr_p;

  assign raw_in  = {fast_clr_i, selftest_i, test_stop_i, start_i, stop_i};
  assign stop_p  = pulse[N_CH-1:0];
  assign start_p = pulse[N_CH];
  assign tstop_p = pulse[N_CH+1];
  assign self_p  = pulse[N_CH+2];
  assign clr_p   = pulse[N_CH+3];

  tdc_sync_edge #(.W(SW)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_in),
    .rise_o (pulse)
  );

  logic chan_start, self_stop, conv_done;
  logic [N_CH-1:0] run_v, ovf_v, nz_v;
  logic [N_CH-1:0][CNT_W-1:0] val_v;

  tdc_ctrl #(.N_CH(N_CH), .SELF_CNT(SELF_CNT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_p),
    .start_i     (start_p),
    .selftest_i  (self_p),
    .run_i       (run_v),
    .chan_start_o(chan_start),
    .self_stop_o (self_stop),
    .busy_o      (busy_o),
    .done_o      (conv_done)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tdc_channel #(.CNT_W(CNT_W), .FULL(FULL)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_p),
      .start_i(chan_start),
      .stop_i (stop_p[g] | tstop_p | self_stop),
      .run_o  (run_v[g]),
      .val_o  (val_v[g]),
      .ovf_o  (ovf_v[g])
    );
    assign nz_v[g] = |val_v[g];
  end

  assign any_data_o = |nz_v;
  assign lam_o      = lam_en_i && conv_done && any_data_o;

  logic           rsp_v_q, rsp_q_q;
  logic [CNT_W:0] rsp_d_q;

  assign rd_req_ready_o = !rsp_v_q || rd_rsp_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q_q <= 1'b0;
      rsp_d_q <= '0;
    end else if (rd_req_valid_i && rd_req_ready_o) begin
      rsp_v_q <= 1'b1;
      rsp_q_q <= any_data_o;
      rsp_d_q <= {ovf_v[rd_addr_i], val_v[rd_addr_i]};
    end else if (rd_rsp_ready_i) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rd_rsp_valid_o = rsp_v_q;
  assign rd_rsp_data_o  = rsp_d_q;
  assign rd_rsp_q_o     = rsp_q_q;
endmodule

// File: rtl/tdc_octal_chk.sv
module tdc_octal_chk #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned FULL  = 1945
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lam_o,
  input logic           lam_en_i,
  input logic           any_data_o,
  input logic           busy_o,
  input logic           clr_p,
  input logic           rd_req_ready_o,
  input logic           rd_rsp_valid_o,
  input logic           rd_rsp_ready_i,
  input logic [CNT_W:0] rd_rsp_data_o
);
  // R8
  lam_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lam_o |-> (lam_en_i && any_data_o));

  // R8
  lam_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lam_o |-> !busy_o);

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |=> (!any_data_o && !busy_o && !lam_o));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid_o && !rd_rsp_ready_i) |=> (rd_rsp_valid_o && $stable(rd_rsp_data_o)));

  // R10
  req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid_o && !rd_rsp_ready_i) |-> !rd_req_ready_o);

  // R3
  full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid_o |-> (rd_rsp_data_o[CNT_W-1:0] <= CNT_W'(FULL)));
endmodule

bind tdc_octal tdc_octal_chk #(.CNT_W(CNT_W), .FULL(FULL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lam_o         (lam_o),
  .lam_en_i      (lam_en_i),
  .any_data_o    (any_data_o),
  .busy_o        (busy_o),
  .clr_p         (clr_p),
  .rd_req_ready_o(rd_req_ready_o),
  .rd_rsp_valid_o(rd_rsp_valid_o),
  .rd_rsp_ready_i(rd_rsp_ready_i),
  .rd_rsp_data_o (rd_rsp_data_o)
);

// File: tb/tdc_octal_tb.sv
module tdc_octal_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FULL = 1945;
  localparam int SELF = 1556;
  localparam int NV = 4;
  // stop delay per channel in clocks after start; 0 means no stop
  localparam int VEC [NV][8] = '{
    '{1, 2, 3, 4, 5, 6, 7, 8},
    '{1944, 1945, 1946, 0, 500, 1000, 17, 1},
    '{10, 10, 10, 10, 10, 10, 10, 10},
    '{0, 0, 0, 0, 0, 0, 0, 0}
  };

  logic clk = 0, rst_n = 0;
  logic start_i = 0, test_stop_i = 0, selftest_i = 0, fast_clr_i = 0, lam_en_i = 1;
  logic [7:0] stop_i = '0;
  logic rd_req_valid_i = 0, rd_rsp_ready_i = 0;
  logic [2:0] rd_addr_i = '0;
  logic rd_req_ready_o, rd_rsp_valid_o, rd_rsp_q_o, busy_o, any_data_o, lam_o;
  logic [11:0] rd_rsp_data_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdc_octal u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .test_stop_i(test_stop_i), .selftest_i(selftest_i), .fast_clr_i(fast_clr_i),
    .lam_en_i(lam_en_i), .rd_req_valid_i(rd_req_valid_i), .rd_req_ready_o(rd_req_ready_o),
    .rd_addr_i(rd_addr_i), .rd_rsp_valid_o(rd_rsp_valid_o), .rd_rsp_ready_i(rd_rsp_ready_i),
    .rd_rsp_data_o(rd_rsp_data_o), .rd_rsp_q_o(rd_rsp_q_o), .busy_o(busy_o),
    .any_data_o(any_data_o), .lam_o(lam_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_ch(input int ch, output int data, output int q);
    @(negedge clk);
    rd_req_valid_i = 1; rd_addr_i = 3'(ch);
    @(negedge clk);
    rd_req_valid_i = 0; rd_rsp_ready_i = 1;
    data = int'(rd_rsp_data_o); q = int'(rd_rsp_q_o);
    @(negedge clk);
    rd_rsp_ready_i = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    start_i = 0; stop_i = '0; test_stop_i = 0; selftest_i = 0; fast_clr_i = 1;
    @(negedge clk);
    fast_clr_i = 0;
    wait_n(5);
  endtask

  function automatic int exp_of(input int n);
    if (n == 0 || n > FULL) return FULL + 2048;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d, q;
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    // R11 reset state
    check("R11 busy", int'(busy_o), 0);
    check("R11 lam", int'(lam_o), 0);
    check("R11 any_data", int'(any_data_o), 0);
    check("R11 rsp_valid", int'(rd_rsp_valid_o), 0);
    check("R11 req_ready", int'(rd_req_ready_o), 1);
    read_ch(5, d, q);
    check("R11 result zero", d, 0);

    // R1 R3 vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); start_i = 1;
      for (int t = 1; t <= 2000; t++) begin
        @(negedge clk);
        for (int c = 0; c < 8; c++) if (VEC[v][c] == t) stop_i[c] = 1;
      end
      check("R8 lam at end", int'(lam_o), 1);
      check("R1 busy low at end", int'(busy_o), 0);
      for (int c = 0; c < 8; c++) begin
        read_ch(c, d, q);
        check("R1/R3 channel value", d, exp_of(VEC[v][c]));
        check("R9 rsp q", q, 1);
      end
      do_clear();
    end

    // R2 R4: early stop, stop with start, repeated stop, then common test stop
    @(negedge clk); stop_i[0] = 1;
    wait_n(5);
    start_i = 1; stop_i[2] = 1;
    for (int t = 1; t <= 320; t++) begin
      @(negedge clk);
      if (t == 20) stop_i[1] = 1;
      if (t == 21) stop_i[1] = 0;
      if (t == 30) stop_i[1] = 1;
      if (t == 40) stop_i[3] = 1;
      if (t == 300) test_stop_i = 1;
    end
    read_ch(0, d, q); check("R2 early stop discarded", d, 300);
    read_ch(1, d, q); check("R2 second stop ignored", d, 20);
    read_ch(2, d, q); check("R2 stop with start discarded", d, 300);
    read_ch(3, d, q); check("R4 earlier own stop kept", d, 40);
    read_ch(7, d, q); check("R4 common stop", d, 300);

    // R7 new start while results held
    @(negedge clk); start_i = 0; selftest_i = 0;
    wait_n(5);
    start_i = 1; selftest_i = 1;
    wait_n(50);
    check("R7 busy stays low", int'(busy_o), 0);
    read_ch(1, d, q); check("R7 result kept", d, 20);

    // R8 lam enable gating
    lam_en_i = 0;
    @(negedge clk); check("R8 lam disabled", int'(lam_o), 0);
    lam_en_i = 1;
    @(negedge clk); check("R8 lam enabled", int'(lam_o), 1);
    do_clear();

    // R6 R9 clear in mid-conversion
    @(negedge clk); start_i = 1;
    wait_n(100);
    check("R6 busy before clear", int'(busy_o), 1);
    do_clear();
    check("R6 busy after clear", int'(busy_o), 0);
    check("R6 lam after clear", int'(lam_o), 0);
    check("R9 any_data empty", int'(any_data_o), 0);
    read_ch(4, d, q);
    check("R6 result zero", d, 0);
    check("R9 q suppressed", q, 0);

    // R5 self-test
    @(negedge clk); selftest_i = 1;
    wait_n(1600);
    check("R5 done lam", int'(lam_o), 1);
    for (int c = 0; c < 8; c++) begin
      read_ch(c, d, q);
      check("R5 self value", d, SELF);
    end

    // R10 back-pressure
    @(negedge clk); rd_req_valid_i = 1; rd_addr_i = 3'd0;
    @(negedge clk); rd_addr_i = 3'd1;
    check("R10 rsp valid", int'(rd_rsp_valid_o), 1);
    check("R10 req stalled", int'(rd_req_ready_o), 0);
    @(negedge clk);
    check("R10 data held", int'(rd_rsp_data_o), SELF);
    rd_req_valid_i = 0; rd_rsp_ready_i = 1;
    @(negedge clk); rd_rsp_ready_i = 0;
    check("R10 drained", int'(rd_rsp_valid_o), 0);
    do_clear();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule